// File: doc/BRIEF.md
# Video Controller Command Port Decoder

This block is the host-facing front end of a tile-based video controller. The host writes 16-bit control words to the control port and 16-bit data words to the data port, or reads data words from the data port. A control word is either a register write or one half of a two-word access command. A 32-bit control write supplies both halves of a command in one access.

The block keeps three pieces of access state: a 6-bit access code, the target memory (video RAM, colour RAM or vertical-scroll RAM) and a 16-bit access address. Data-port accesses read or write the selected memory at that address, then advance the address by the auto-increment register. The block signals the start of the three block-transfer kinds: memory to video RAM, video RAM copy and fill. The transfer engines are outside this block. The three memories are internal word arrays indexed by address bits above bit 0.

The source and length of a transfer come from dedicated registers. A data-port write that arrives while a fill is armed latches the written word as the fill value and starts the fill.

Top module: `vdp_port_front`

## Requirements
- R1: A control word whose bits 15:14 are 2'b10 writes bits 7:0 into register number bits 12:8. Register numbers 24 and above are ignored. A register write clears the pending-half flag. Register 15 is the auto-increment. Registers 20 and 19 are the high and low bytes of `dma_len`. `dma_src` is register 23 bits 6:0, then register 22, then register 21. Register 23 bit 7 is the fill-select bit.
- R2: A 16-bit control word that is not a register write, arriving with no half pending, is held as the first half and sets `half_pending`. The access code and access address are unchanged.
- R3: A 16-bit non-register control word arriving with a half pending completes the command and clears `half_pending`. The new code is {second[7:4], first[15:14]}. The new address is {second[1:0], first[13:0]}.
- R4: A 32-bit control write uses bits 31:16 as the first half and bits 15:0 as the second half, whatever the pending state. If bits 31:16 form a register write, only that register write happens.
- R5: `acc_target` is decoded from code bits 3:1. The value 0 selects video RAM (encoding 0). The value 2 selects vertical-scroll RAM (encoding 2). Any other value selects colour RAM (encoding 1).
- R6: `dma_start` pulses for one cycle after a completed command when the new code has bit 5 set. If code bit 4 is also set, `dma_kind` is copy (2). If code bit 4 is clear and the fill-select bit is 0, `dma_kind` is memory-to-video (1). If code bit 4 is clear and the fill-select bit is 1, there is no pulse and the fill stays armed.
- R7: When code bits 5:4 are 2'b10, a data-port write latches its low 16 bits into `fill_word` and pulses `dma_start` with `dma_kind` fill (3). The memory is not written.
- R8: Any other data-port write stores its low 16 bits into the target memory at word index address[AW:1].
- R9: Every data-port read or write adds the auto-increment register, zero-extended, to the access address, modulo 2^16.
- R10: Bus offset bit 2 selects the control port (1) or the data port (0). Offset bit 1 has no effect, so offsets 0/2 and 4/6 alias.
- R11: A data-port read returns the target word at the current address on `bus_rdata` in the cycle after the read.
- R12: After reset the code, address, pending flag, registers, `fill_word` and `dma_start` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_long | input | 1 | Control write carries 32 bits |
| bus_ofs | input | 2 | Port offset bits 2:1 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 16 | Data-port read result |
| half_pending | output | 1 | First half of a command is held |
| acc_code | output | 6 | Current access code |
| acc_addr | output | 16 | Current access address |
| acc_target | output | 2 | Selected memory |
| dma_start | output | 1 | Transfer start pulse |
| dma_kind | output | 2 | Transfer kind for the pulse |
| dma_src | output | 23 | Transfer source address |
| dma_len | output | 16 | Transfer length |
| fill_word | output | 16 | Latched fill value |

## Verification
The assertions assume that at most one of control write, data write and data read happens in a cycle. The bench never drives `bus_wr` and `bus_rd` together. Each access is a single strobe cycle followed by an idle cycle. Random control words, register writes, 32-bit commands and data accesses come from a fixed seed. Directed cases cover aliasing, the fill-select bit and a fill write that must leave memory untouched. A reference model in the bench tracks codes, addresses and memory contents, and compares reads only against words it has already written.

// File: rtl/vdp_cmd_pkg.sv
package vdp_cmd_pkg;

    typedef enum logic [1:0] {
        TGT_VRAM  = 2'd0,
        TGT_CRAM  = 2'd1,
        TGT_VSRAM = 2'd2
    } target_e;

    typedef enum logic [1:0] {
        DMA_NONE = 2'd0,
        DMA_MEM  = 2'd1,
        DMA_COPY = 2'd2,
        DMA_FILL = 2'd3
    } dma_kind_e;

    typedef struct packed {
        logic [5:0]  code;
        logic [15:0] addr;
    } access_t;

    function automatic logic is_reg_word(input logic [15:0] w);
        return w[15:14] == 2'b10;
    endfunction

    function automatic access_t join_cmd(input logic [15:0] first, input logic [15:0] second);
        access_t j;
        j.code = {second[7:4], first[15:14]};
        j.addr = {second[1:0], first[13:0]};
        return j;
    endfunction

    function automatic target_e decode_target(input logic [5:0] code);
        case (code[3:1])
            3'd0:    return TGT_VRAM;
            3'd2:    return TGT_VSRAM;
            default: return TGT_CRAM;
        endcase
    endfunction

endpackage

// File: rtl/vdp_regfile.sv
module vdp_regfile #(
    parameter int NREG        = 24,
    parameter int AUTOINC_IDX = 15,
    parameter int LEN_LO_IDX  = 19,
    parameter int LEN_HI_IDX  = 20,
    parameter int SRC_LO_IDX  = 21,
    parameter int SRC_MID_IDX = 22,
    parameter int SRC_HI_IDX  = 23
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [4:0]  idx,
    input  logic [7:0]  val,
    output logic [7:0]  autoinc,
    output logic [15:0] dma_len,
    output logic [22:0] dma_src,
    output logic        fill_mode
);
    localparam int IW = $clog2(NREG);

    logic [7:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && int'(idx) < NREG) begin
            regs[idx[IW-1:0]] <= val;
        end
    end

    assign autoinc   = regs[AUTOINC_IDX];
    assign dma_len   = {regs[LEN_HI_IDX], regs[LEN_LO_IDX]};
    assign dma_src   = {regs[SRC_HI_IDX][6:0], regs[SRC_MID_IDX], regs[SRC_LO_IDX]};
    assign fill_mode = regs[SRC_HI_IDX][7];

endmodule

// File: rtl/vdp_cmd_seq.sv
module vdp_cmd_seq
    import vdp_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_wr,
    input  logic        ctl_long,
    input  logic [31:0] ctl_word,
    input  logic        dat_wr,
    input  logic        dat_rd,
    input  logic [15:0] dat_word,
    input  logic [7:0]  autoinc,
    input  logic        fill_mode,
    output logic        reg_we,
    output logic [4:0]  reg_idx,
    output logic [7:0]  reg_val,
    output access_t     acc,
    output logic        pending,
    output logic        mem_we,
    output logic        dma_start,
    output dma_kind_e   dma_kind,
    output logic [15:0] fill_word
);
    logic [15:0] head, lead, first_q;
    logic        complete, fill_hit;
    access_t     nxt;

    always_comb begin
        head     = ctl_long ? ctl_word[31:16] : ctl_word[15:0];
        reg_we   = ctl_wr && is_reg_word(head);
        reg_idx  = head[12:8];
        reg_val  = head[7:0];
        complete = ctl_wr && !reg_we && (ctl_long || pending);
        lead     = ctl_long ? ctl_word[31:16] : first_q;
        nxt      = join_cmd(lead, ctl_word[15:0]);
        fill_hit = dat_wr && (acc.code[5:4] == 2'b10);
        mem_we   = dat_wr && !fill_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            pending   <= 1'b0;
            first_q   <= '0;
            dma_start <= 1'b0;
            dma_kind  <= DMA_NONE;
            fill_word <= '0;
        end else begin
            dma_start <= 1'b0;
            dma_kind  <= DMA_NONE;
            if (reg_we) begin
                pending <= 1'b0;
            end else if (complete) begin
                acc     <= nxt;
                pending <= 1'b0;
                if (nxt.code[5]) begin
                    if (nxt.code[4]) begin
                        dma_start <= 1'b1;
                        dma_kind  <= DMA_COPY;
                    end else if (!fill_mode) begin
                        dma_start <= 1'b1;
                        dma_kind  <= DMA_MEM;
                    end
                end
            end else if (ctl_wr) begin
                first_q <= ctl_word[15:0];
                pending <= 1'b1;
            end
            if (dat_wr || dat_rd) begin
                acc.addr <= acc.addr + {8'h00, autoinc};
            end
            if (fill_hit) begin
                fill_word <= dat_word;
                dma_start <= 1'b1;
                dma_kind  <= DMA_FILL;
            end
        end
    end

    // R2: holding a first half leaves the access state alone
    p_first_half_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !ctl_long && !pending && !is_reg_word(ctl_word[15:0]))
        |=> (pending && acc == $past(acc)));

    // R3: a completed command leaves no half pending
    p_complete_r3: assert property (@(posedge clk) disable iff (rst)
        complete |=> !pending);

    // R1: a register write drops a pending half
    p_reg_clear_r1: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !pending);

    // R9: data accesses advance the address by the auto-increment
    p_advance_r9: assert property (@(posedge clk) disable iff (rst)
        ((dat_wr || dat_rd) && !ctl_wr)
        |=> acc.addr == $past(acc.addr) + {8'h00, $past(autoinc)});

    // R7: a fill start is always caused by a data-port write
    p_fill_src_r7: assert property (@(posedge clk) disable iff (rst)
        (dma_start && dma_kind == DMA_FILL) |-> $past(dat_wr));

    // R6: a non-fill start always follows a control write
    p_cmd_src_r6: assert property (@(posedge clk) disable iff (rst)
        (dma_start && dma_kind != DMA_FILL) |-> $past(ctl_wr));

endmodule

// File: rtl/vdp_mem_bank.sv
module vdp_mem_bank
    import vdp_cmd_pkg::*;
#(
    parameter int VRAM_AW  = 10,
    parameter int CRAM_AW  = 6,
    parameter int VSRAM_AW = 6
) (
    input  logic        clk,
    input  logic        we,
    input  logic        re,
    input  target_e     tgt,
    input  logic [15:0] addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata
);
    target_e sel_q;

    for (genvar g = 0; g < 3; g++) begin : g_bank
        localparam int AW = (g == 0) ? VRAM_AW : ((g == 1) ? CRAM_AW : VSRAM_AW);
        logic [15:0] store [2**AW];
        logic [15:0] rd_q;
        always_ff @(posedge clk) begin
            if (we && tgt == target_e'(g)) store[addr[AW:1]] <= wdata;
            if (re && tgt == target_e'(g)) rd_q <= store[addr[AW:1]];
        end
    end

    always_ff @(posedge clk) begin
        if (re) sel_q <= tgt;
    end

    always_comb begin
        case (sel_q)
            TGT_VRAM:  rdata = g_bank[0].rd_q;
            TGT_CRAM:  rdata = g_bank[1].rd_q;
            default:   rdata = g_bank[2].rd_q;
        endcase
    end

endmodule

// File: rtl/vdp_port_front.sv
module vdp_port_front
    import vdp_cmd_pkg::*;
#(
    parameter int NREG     = 24,
    parameter int VRAM_AW  = 10,
    parameter int CRAM_AW  = 6,
    parameter int VSRAM_AW = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic        bus_long,
    input  logic [2:1]  bus_ofs,
    input  logic [31:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        half_pending,
    output logic [5:0]  acc_code,
    output logic [15:0] acc_addr,
    output logic [1:0]  acc_target,
    output logic        dma_start,
    output logic [1:0]  dma_kind,
    output logic [22:0] dma_src,
    output logic [15:0] dma_len,
    output logic [15:0] fill_word
);
    logic       ctl_wr, dat_wr, dat_rd, ofs_unused;
    logic       reg_we, mem_we, fill_mode;
    logic [4:0] reg_idx;
    logic [7:0] reg_val, autoinc;
    access_t    acc;
    dma_kind_e  kind;
    target_e    tgt;

    assign ctl_wr     = bus_wr && bus_ofs[2];
    assign dat_wr     = bus_wr && !bus_ofs[2];
    assign dat_rd     = bus_rd && !bus_ofs[2];
    assign ofs_unused = bus_ofs[1];

    vdp_regfile #(.NREG(NREG)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we),
        .idx       (reg_idx),
        .val       (reg_val),
        .autoinc   (autoinc),
        .dma_len   (dma_len),
        .dma_src   (dma_src),
        .fill_mode (fill_mode)
    );

    vdp_cmd_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (ctl_wr),
        .ctl_long  (bus_long),
        .ctl_word  (bus_wdata),
        .dat_wr    (dat_wr),
        .dat_rd    (dat_rd),
        .dat_word  (bus_wdata[15:0]),
        .autoinc   (autoinc),
        .fill_mode (fill_mode),
        .reg_we    (reg_we),
        .reg_idx   (reg_idx),
        .reg_val   (reg_val),
        .acc       (acc),
        .pending   (half_pending),
        .mem_we    (mem_we),
        .dma_start (dma_start),
        .dma_kind  (kind),
        .fill_word (fill_word)
    );

    assign tgt = decode_target(acc.code);

    vdp_mem_bank #(.VRAM_AW(VRAM_AW), .CRAM_AW(CRAM_AW), .VSRAM_AW(VSRAM_AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .re    (dat_rd),
        .tgt   (tgt),
        .addr  (acc.addr),
        .wdata (bus_wdata[15:0]),
        .rdata (bus_rdata)
    );

    assign acc_code   = acc.code;
    assign acc_addr   = acc.addr;
    assign acc_target = tgt;
    assign dma_kind   = kind;

    // R10: the access state moves only on a strobe
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && !bus_rd) |=> ($stable(acc_code) && $stable(acc_addr) && $stable(half_pending)));

endmodule

// File: tb/tb_vdp_port_front.sv
module tb_vdp_port_front;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_rd, bus_long;
    logic [2:1]  bus_ofs;
    logic [31:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        half_pending;
    logic [5:0]  acc_code;
    logic [15:0] acc_addr;
    logic [1:0]  acc_target;
    logic        dma_start;
    logic [1:0]  dma_kind;
    logic [22:0] dma_src;
    logic [15:0] dma_len;
    logic [15:0] fill_word;

    always #5ns clk = ~clk;

    vdp_port_front dut (.*);

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0]  m_regs [24];
    logic        m_pend;
    logic [15:0] m_first, m_addr, m_fill, m_rd;
    logic [5:0]  m_code;
    logic        e_start, e_rdok;
    logic [1:0]  e_kind;
    logic [15:0] mm [3][1024];
    bit          mv [3][1024];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int tgt_of(input logic [5:0] c);
        if (c[3:1] == 3'd0) return 0;
        if (c[3:1] == 3'd2) return 2;
        return 1;
    endfunction

    function automatic int widx(input int t, input logic [15:0] a);
        return (t == 0) ? int'(a[10:1]) : int'(a[6:1]);
    endfunction

    task automatic m_reg(input logic [15:0] w);
        if (int'(w[12:8]) < 24) m_regs[w[12:8]] = w[7:0];
        m_pend = 1'b0;
    endtask

    task automatic m_complete(input logic [15:0] f, input logic [15:0] s);
        m_code = {s[7:4], f[15:14]};
        m_addr = {s[1:0], f[13:0]};
        m_pend = 1'b0;
        if (m_code[5]) begin
            if (m_code[4]) begin e_start = 1; e_kind = 2; end
            else if (!m_regs[23][7]) begin e_start = 1; e_kind = 1; end
        end
    endtask

    task automatic post_check(input string tag);
        check({tag, " pending"}, half_pending, m_pend);
        check({tag, " code"}, acc_code, m_code);
        check({tag, " addr"}, acc_addr, m_addr);
        check({tag, " R5 target"}, acc_target, tgt_of(m_code));
        check({tag, " R6 start"}, dma_start, e_start);
        if (e_start) check({tag, " R6 kind"}, dma_kind, e_kind);
        check({tag, " R7 fill"}, fill_word, m_fill);
        check({tag, " R1 len"}, dma_len, {m_regs[20], m_regs[19]});
        check({tag, " R1 src"}, dma_src, {m_regs[23][6:0], m_regs[22], m_regs[21]});
        if (e_rdok) check({tag, " R11 rdata"}, bus_rdata, m_rd);
    endtask

    task automatic strobe(input bit wr, input bit rd, input bit lng, input logic [2:1] ofs, input logic [31:0] w);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_long = lng; bus_ofs = ofs; bus_wdata = w;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; bus_long = 0;
    endtask

    task automatic ctl16(input logic [15:0] w, input bit alt, input string tag);
        e_start = 0; e_rdok = 0;
        if (w[15:14] == 2'b10) m_reg(w);
        else if (m_pend) m_complete(m_first, w);
        else begin m_first = w; m_pend = 1; end
        strobe(1, 0, 0, {1'b1, alt}, {16'hDEAD, w});
        post_check(tag);
    endtask

    task automatic ctl32(input logic [31:0] w, input string tag);
        e_start = 0; e_rdok = 0;
        if (w[31:30] == 2'b10) m_reg(w[31:16]);
        else m_complete(w[31:16], w[15:0]);
        strobe(1, 0, 1, 2'b10, w);
        post_check(tag);
    endtask

    task automatic dwr(input logic [15:0] w, input bit alt, input string tag);
        int t;
        e_start = 0; e_rdok = 0;
        t = tgt_of(m_code);
        if (m_code[5:4] == 2'b10) begin
            m_fill = w; e_start = 1; e_kind = 3;
        end else begin
            mm[t][widx(t, m_addr)] = w;
            mv[t][widx(t, m_addr)] = 1;
        end
        m_addr = m_addr + {8'h00, m_regs[15]};
        strobe(1, 0, 0, {1'b0, alt}, {16'hBEEF, w});
        post_check(tag);
    endtask

    task automatic drd(input bit alt, input string tag);
        int t;
        e_start = 0;
        t = tgt_of(m_code);
        e_rdok = mv[t][widx(t, m_addr)];
        m_rd = mm[t][widx(t, m_addr)];
        m_addr = m_addr + {8'h00, m_regs[15]};
        strobe(0, 1, 0, {1'b0, alt}, 32'h0);
        post_check(tag);
    endtask

    task automatic set_cmd(input logic [5:0] c, input logic [15:0] a, input string tag);
        ctl16({c[1:0], a[13:0]}, 0, tag);
        ctl16({8'h00, c[5:2], 2'b00, a[15:14]}, 1, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        bus_wr = 0; bus_rd = 0; bus_long = 0; bus_ofs = 2'b00; bus_wdata = '0;
        for (int i = 0; i < 24; i++) m_regs[i] = 8'h00;
        for (int t = 0; t < 3; t++) for (int i = 0; i < 1024; i++) mv[t][i] = 0;
        m_pend = 0; m_first = 0; m_addr = 0; m_code = 0; m_fill = 0; m_rd = 0;
        e_start = 0; e_kind = 0; e_rdok = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        @(negedge clk);
        post_check("R12 reset");

        // R1 registers: auto-increment, length, source
        ctl16(16'h8F02, 0, "R1 autoinc");
        ctl16(16'h9334, 1, "R1 len lo");
        ctl16(16'h9412, 0, "R1 len hi");
        ctl16(16'h9556, 0, "R1 src lo");
        ctl16(16'h9678, 0, "R1 src mid");
        ctl16(16'h971A, 0, "R1 src hi");
        ctl16(16'h9FFF, 0, "R1 ignored index");

        // R2 then R3, R5 vertical-scroll target
        ctl16(16'h7ABC, 0, "R2 first half");
        ctl16(16'h0012, 0, "R3 second half");
        // R1: register write drops a pending half
        ctl16(16'h4000, 0, "R1 pre");
        ctl16(16'h8F02, 0, "R1 clears pending");
        // R4 long write
        ctl32(32'h4010_0000, "R4 long cmd");
        ctl32(32'h8F04_1234, "R4 long register");
        ctl16(16'h8F02, 0, "R4 restore");

        // R8, R9, R10, R11: write VRAM then read back with aliased offset
        set_cmd(6'h01, 16'h0010, "R8 vram cmd");
        dwr(16'hA001, 0, "R8 write0");
        dwr(16'hA002, 1, "R10 write alias");
        dwr(16'hA003, 0, "R9 write2");
        set_cmd(6'h00, 16'h0010, "R11 read cmd");
        drd(1, "R10 read alias");
        drd(0, "R11 read1");
        drd(0, "R11 read2");
        // CRAM target
        set_cmd(6'h03, 16'h0020, "R5 cram cmd");
        dwr(16'h0EEE, 0, "R8 cram write");
        set_cmd(6'h08, 16'h0020, "R5 cram read cmd");
        drd(0, "R11 cram read");

        // R6 copy, memory transfer, armed fill
        set_cmd(6'h30, 16'h0100, "R6 copy");
        set_cmd(6'h21, 16'h0100, "R6 mem transfer");
        ctl16(16'h979A, 0, "R6 fill select on");
        set_cmd(6'h21, 16'h0010, "R6 armed no pulse");
        // R7 fill: memory untouched
        dwr(16'h5555, 0, "R7 fill start");
        set_cmd(6'h00, 16'h0010, "R7 readback cmd");
        drd(0, "R7 memory unchanged");
        ctl16(16'h971A, 0, "R6 fill select off");

        // random mix
        for (int n = 0; n < 800; n++) begin
            int op;
            logic [15:0] w;
            op = $urandom_range(0, 9);
            w = 16'($urandom);
            case (op)
                0, 1: ctl16({3'b100, 5'($urandom_range(15, 24)), w[7:0]}, w[8], "R1 rand reg");
                2, 3: ctl16({~w[15], w[14:0]}, w[3], "R3 rand cmd");
                4:    ctl32({~w[15], w[14:0], 16'($urandom)}, "R4 rand long");
                5, 6: dwr(w, w[0], "R8 rand write");
                7, 8: drd(w[0], "R11 rand read");
                default: ctl16(w, w[1], "R2 rand ctl");
            endcase
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule